// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block refills one cache line after a demand load misses. It takes the byte address of the miss and issues a single burst request to the memory side. It then receives the line as a series of data-bus-wide beats, starting with the chunk that holds the missing load and wrapping around to the line base. The default line is 64 bytes, sent as eight 8-byte beats over a 64-bit bus.

The beat that holds the demanded data is passed to the waiting load in the same cycle it arrives. The load does not wait for the rest of the line. Each beat is written into an internal line buffer at its true offset within the line. One cycle after the final beat, a one-cycle line-valid pulse presents the whole line and its base address.

The memory side signals each beat with a valid strobe and may leave idle cycles between beats. Only one miss is handled at a time. Tag lookup, replacement and the memory controller itself are handled elsewhere.

Top module: `crit_line_fill`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req, fwd_valid and line_valid are 0.
- R2: A miss is accepted on a clock edge where miss_valid and miss_ready are both 1. While a fill is in progress miss_ready is 0, and miss_valid has no effect: no extra request is issued and the line in flight keeps its own address.
- R3: In the cycle after a miss is accepted, mem_req is 1 for exactly one cycle. mem_req_addr equals the miss address with its low 3 bits cleared, which is the critical 8-byte chunk.
- R4: fwd_valid is 1 in the same cycle as the first beat of a fill (mem_beat_valid=1), and fwd_data equals that beat's data. fwd_valid stays 0 on every later beat.
- R5: The k-th beat of a fill (k from 0) is the chunk at offset (c+k) mod 8, where c is miss address bits [5:3]. Chunk j is stored in line_data bits [64*j+63 : 64*j].
- R6: line_valid is 1 for exactly one cycle, in the cycle after the eighth beat is taken. In that cycle line_addr equals the miss address with its low 6 bits cleared, and miss_ready is already 1 again.
- R7: Any number of idle cycles (mem_beat_valid=0) between beats leaves the fill result unchanged.
- R8: mem_beat_valid while no fill is in progress is ignored. It raises neither fwd_valid nor line_valid, and it does not disturb the next fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | ADDR_W (32) | Byte address of the missing load |
| miss_ready | output | 1 | Sequencer idle, miss can be accepted |
| mem_req | output | 1 | One-cycle burst request to memory |
| mem_req_addr | output | ADDR_W (32) | Address of the critical chunk (burst start) |
| mem_beat_valid | input | 1 | A data beat is present |
| mem_beat_data | input | DATA_W (64) | Beat data |
| fwd_valid | output | 1 | Demanded beat forwarded this cycle |
| fwd_data | output | DATA_W (64) | Forwarded beat data |
| line_valid | output | 1 | One-cycle pulse: line complete |
| line_addr | output | ADDR_W (32) | Base address of the completed line |
| line_data | output | DATA_W*BEATS (512) | Completed line, chunk j at bits [64*j +: 64] |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 64-bit beats and eight beats per line. At these values every critical offset from 0 to 7 can be driven directly, including offset 0 (no wrap) and offset 7 (wrap after the first beat). Misses with gaps of zero, one and three idle cycles between beats check that the order and final placement do not depend on beat spacing. Stray beats while idle and a second miss raised during a fill confirm that neither changes the request count or the completed line.

// File: rtl/crit_line_fill.sv
module crit_line_fill #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_addr,
  output logic                    miss_ready,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_beat_valid,
  input  logic [DATA_W-1:0]       mem_beat_data,
  output logic                    fwd_valid,
  output logic [DATA_W-1:0]       fwd_data,
  output logic                    line_valid,
  output logic [ADDR_W-1:0]       line_addr,
  output logic [DATA_W*BEATS-1:0] line_data
);
  localparam int OFF_W    = $clog2(DATA_W / 8);
  localparam int IDX_W    = $clog2(BEATS);
  localparam int LINE_LSB = OFF_W + IDX_W;

  logic                          busy;
  logic [IDX_W-1:0]              idx;
  logic [IDX_W-1:0]              cnt;
  logic [ADDR_W-1:0]             base;
  logic [BEATS-1:0][DATA_W-1:0]  buf_q;

  wire accept = miss_valid && !busy;
  wire take   = busy && mem_beat_valid;
  wire last   = take && (&cnt);

  assign miss_ready = !busy;
  assign fwd_valid  = take && (cnt == '0);
  assign fwd_data   = mem_beat_data;
  assign line_addr  = base;
  assign line_data  = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      mem_req      <= 1'b0;
      line_valid   <= 1'b0;
      cnt          <= '0;
      idx          <= '0;
      base         <= '0;
      mem_req_addr <= '0;
    end else begin
      mem_req    <= accept;
      line_valid <= last;
      if (accept) begin
        busy         <= 1'b1;
        cnt          <= '0;
        idx          <= miss_addr[LINE_LSB-1:OFF_W];
        base         <= {miss_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
        mem_req_addr <= {miss_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end else if (take) begin
        cnt <= cnt + 1'b1;
        idx <= idx + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) buf_q[idx] <= mem_beat_data;
  end

  // R6
  line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> !line_valid);

  // R6
  ready_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> miss_ready);

  // R3
  req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(miss_valid && miss_ready));

  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4
  fwd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (!miss_ready && mem_beat_valid));

  // R2
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_ready && !mem_beat_valid) |=> !miss_ready);

  // R4
  no_fwd_with_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && line_valid));
endmodule

// File: tb/test_crit_line_fill.sv
`timescale 1ns/1ps
module test_crit_line_fill;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int BEATS  = 8;
  localparam int LINE_W = DATA_W * BEATS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              miss_valid = 1'b0;
  logic [ADDR_W-1:0] miss_addr = '0;
  logic              miss_ready;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_beat_valid = 1'b0;
  logic [DATA_W-1:0] mem_beat_data = '0;
  logic              fwd_valid;
  logic [DATA_W-1:0] fwd_data;
  logic              line_valid;
  logic [ADDR_W-1:0] line_addr;
  logic [LINE_W-1:0] line_data;

  always #10 clk = ~clk;

  crit_line_fill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) i_crit_line_fill (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .mem_req(mem_req), .mem_req_addr(mem_req_addr),
    .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .line_valid(line_valid),
    .line_addr(line_addr), .line_data(line_data));

  int total = 0;
  int bad = 0;
  int n_req = 0;
  int n_req_exp = 0;
  bit done = 1'b0;

  logic [ADDR_W-1:0] exp_req[$];
  logic [DATA_W-1:0] exp_fwd[$];
  logic [ADDR_W-1:0] exp_la[$];
  logic [LINE_W-1:0] exp_line[$];

  function automatic logic [DATA_W-1:0] chunk(logic [ADDR_W-1:0] base, int j);
    return {base, 16'hC0DE, 13'd0, 3'(j)};
  endfunction

  task automatic check(string req, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (mem_req) begin
      n_req++;
      if (exp_req.size() == 0) check("R2/R3 unexpected mem_req", 1, 0);
      else check("R3 mem_req_addr", LINE_W'(mem_req_addr), LINE_W'(exp_req.pop_front()));
    end
    if (fwd_valid) begin
      if (exp_fwd.size() == 0) check("R4/R8 unexpected fwd_valid", 1, 0);
      else check("R4 fwd_data", LINE_W'(fwd_data), LINE_W'(exp_fwd.pop_front()));
    end
    if (line_valid) begin
      check("R6 miss_ready with line_valid", LINE_W'(miss_ready), 1);
      if (exp_line.size() == 0) check("R6/R8 unexpected line_valid", 1, 0);
      else begin
        check("R6 line_addr", LINE_W'(line_addr), LINE_W'(exp_la.pop_front()));
        check("R5 line_data", line_data, exp_line.pop_front());
      end
    end
  end

  task automatic run_miss(logic [ADDR_W-1:0] addr, int gap, bit poke);
    logic [ADDR_W-1:0] base = {addr[ADDR_W-1:6], 6'd0};
    int c = int'(addr[5:3]);
    logic [LINE_W-1:0] ln;
    for (int j = 0; j < BEATS; j++) ln[j*DATA_W +: DATA_W] = chunk(base, j);
    exp_req.push_back({addr[ADDR_W-1:3], 3'd0});
    exp_fwd.push_back(chunk(base, c));
    exp_la.push_back(base);
    exp_line.push_back(ln);
    n_req_exp++;
    while (!miss_ready) @(posedge clk);
    #2 miss_valid = 1'b1; miss_addr = addr;
    @(posedge clk); #2 miss_valid = 1'b0;
    @(posedge clk);
    for (int k = 0; k < BEATS; k++) begin
      for (int g = 0; g < gap; g++) begin
        #2;
        if (poke && k == 3) begin miss_valid = 1'b1; miss_addr = addr ^ 32'h0000_1038; end
        @(posedge clk);
        #2 miss_valid = 1'b0;
        #0;
      end
      #2 mem_beat_valid = 1'b1; mem_beat_data = chunk(base, (c + k) % BEATS);
      @(posedge clk); #2 mem_beat_valid = 1'b0;
      #0;
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 miss_ready", LINE_W'(miss_ready), 1);
    check("R1 mem_req", LINE_W'(mem_req), 0);
    check("R1 fwd_valid", LINE_W'(fwd_valid), 0);
    check("R1 line_valid", LINE_W'(line_valid), 0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 miss_ready after release", LINE_W'(miss_ready), 1);

    run_miss(32'h0000_1000, 0, 0);
    run_miss(32'h0000_20FC, 0, 0);
    run_miss(32'h1234_5698, 1, 0);
    run_miss(32'hABCD_EF66, 3, 0);
    // R2: miss raised during a fill must be ignored
    run_miss(32'h0000_7FE1, 2, 1);
    // R8: stray beats while idle
    for (int s = 0; s < 3; s++) begin
      @(posedge clk); #2 mem_beat_valid = 1'b1; mem_beat_data = 64'hDEAD_BEEF_0000_0000 | 64'(s);
    end
    @(posedge clk); #2 mem_beat_valid = 1'b0;
    repeat (2) @(posedge clk);
    run_miss(32'h0000_4428, 0, 0);
    for (int c = 0; c < BEATS; c++) run_miss(32'h0008_0000 + 32'(c * 8) + 32'(c), c % 2, 0);

    @(negedge clk);
    check("R2 request count", LINE_W'(n_req), LINE_W'(n_req_exp));
    check("R7 all forwards seen", LINE_W'(exp_fwd.size()), 0);
    check("R8 all lines seen", LINE_W'(exp_line.size()), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule